// File: doc/BRIEF.md
# Multithreaded Dispatch Context Scheduler

This block sits between the fetch stage and the issue stage of a fine-grained multithreaded in-order pipeline. Each thread context owns a small first-in first-out instruction buffer. The fetch stage fills these buffers through one push port per context, and a full flag per context holds that context's fetch back. In every cycle the scheduler picks at most one ready context and presents that context's oldest buffered instruction on a single dispatch output, tagged with the context index. The pick leaves its buffer at the next clock edge.

A context is ready when software has enabled it, the pipeline is not reporting a stall for it, and its buffer holds at least one instruction. A two-bit mode input chooses how one context is picked from the ready set. The modes are rotating selection, fixed priority, and stay-until-stall. A service guarantee can be placed on top of any mode. It forces a grant to a nominated real-time context once a programmable number of cycles has passed without that context being served.

Top module: `thread_dispatch_sched`

## Requirements
- R1: After the active-low asynchronous reset, every buffer is empty, every `full_o` bit is 0 and `disp_valid_o` is 0.
- R2: Each context buffer holds DEPTH (default 4) entries in arrival order. `full_o[i]` is 1 exactly when buffer i holds DEPTH entries. A push while `full_o[i]` is 1 is dropped, and a dropped push never appears at the dispatch output.
- R3: Context i is eligible when `ctx_en_i[i]`=1, `ctx_stall_i[i]`=0 and its buffer is non-empty. Ineligible contexts are never granted. When no context is eligible, `disp_valid_o` is 0. When at least one context is eligible, `disp_valid_o` is 1.
- R4: The dispatch output is combinational in the current buffer state and control inputs. `disp_data_o` is the oldest entry of context `disp_ctx_o`, where `disp_ctx_o` is the binary context index. That entry is removed at the next rising edge. A push is visible at the output from the cycle after it is accepted.
- R5: Mode 0 (rotating) and the unused code 3 grant the first eligible context found by searching upward from the context after the last granted one, with wrap-around.
- R6: Mode 1 (fixed priority) grants the eligible context with the lowest index.
- R7: Mode 2 (stay-until-stall) grants the last granted context again while it is eligible. Otherwise it applies the mode 0 search.
- R8: A service counter is cleared while `qos_en_i`=0 and on every grant to context `qos_ctx_i`. Otherwise it counts up by one each cycle and saturates. When `qos_en_i`=1, counter+1 >= `qos_window_i` and context `qos_ctx_i` is eligible, that context is granted whatever the mode.
- R9: The last-granted record is updated on every grant, forced ones included. Its reset value is the highest context index, so the first rotating search starts at context 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_valid_i | input | NUM_CTX | Per-context push strobe from fetch |
| push_data_i | input | NUM_CTX*DATA_W | Per-context instruction words, context i at bits [i*DATA_W +: DATA_W] |
| full_o | output | NUM_CTX | Per-context buffer full |
| ctx_en_i | input | NUM_CTX | Per-context enable |
| ctx_stall_i | input | NUM_CTX | Per-context stall |
| mode_i | input | 2 | 0 rotating, 1 fixed priority, 2 stay-until-stall, 3 as 0 |
| qos_en_i | input | 1 | Service guarantee enable |
| qos_ctx_i | input | IDX_W | Real-time context index |
| qos_window_i | input | WIN_W | Guarantee window in cycles |
| disp_valid_o | output | 1 | Dispatch valid |
| disp_ctx_o | output | IDX_W | Granted context index |
| disp_data_o | output | DATA_W | Dispatched instruction word |

## Verification
Random push, enable and stall patterns are run in each mode. In rotating mode, a grant that moves on when several contexts are ready shows true rotation rather than a fixed scan. In priority mode, the lowest-index choice is visible only because higher contexts are starved. Stay-until-stall is told apart from rotation by long runs on one context that break only at a stall or an empty buffer. A run that combines priority with the guarantee on the lowest-priority context shows the forced grants appearing at the window limit. A directed overflow sequence with all contexts disabled shows that pushes to a full buffer are dropped and that the arrival order is kept.

// File: rtl/tds_pkg.sv
package tds_pkg;
  typedef enum logic [1:0] {
    SEL_ROUND  = 2'd0,
    SEL_FIXED  = 2'd1,
    SEL_STICKY = 2'd2,
    SEL_RSVD   = 2'd3
  } sel_mode_e;
endpackage

// File: rtl/tds_ctx_fifo.sv
module tds_ctx_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o,
  output logic              full_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              push_ok, pop_ok;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/tds_select.sv
module tds_select
  import tds_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_CTX-1:0] elig_i,
  input  logic [1:0]         mode_i,
  input  logic [IDX_W-1:0]   last_i,
  input  logic               force_i,
  input  logic [IDX_W-1:0]   force_idx_i,
  output logic               gnt_valid_o,
  output logic [IDX_W-1:0]   gnt_idx_o
);
  logic [IDX_W-1:0] rr_idx, fx_idx;
  logic             rr_found;
  sel_mode_e        mode;

  assign mode        = sel_mode_e'(mode_i);
  assign gnt_valid_o = |elig_i;

  always_comb begin
    int cand;
    rr_found = 1'b0;
    rr_idx   = '0;
    for (int k = 1; k <= NUM_CTX; k++) begin
      cand = int'(last_i) + k;
      if (cand >= NUM_CTX) cand = cand - NUM_CTX;
      if (!rr_found && elig_i[cand]) begin
        rr_found = 1'b1;
        rr_idx   = IDX_W'(cand);
      end
    end
  end

  always_comb begin
    fx_idx = '0;
    for (int i = NUM_CTX - 1; i >= 0; i--) begin
      if (elig_i[i]) fx_idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (force_i) begin
      gnt_idx_o = force_idx_i;
    end else begin
      case (mode)
        SEL_FIXED:  gnt_idx_o = fx_idx;
        SEL_STICKY: gnt_idx_o = elig_i[last_i] ? last_i : rr_idx;
        default:    gnt_idx_o = rr_idx;
      endcase
    end
  end
endmodule

// File: rtl/tds_qos_timer.sv
module tds_qos_timer #(
  parameter int WIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             hit_i,
  input  logic [WIN_W-1:0] window_i,
  output logic             due_o
);
  logic [WIN_W-1:0] cnt_q;

  assign due_o = en_i && (({1'b0, cnt_q} + 1'b1) >= {1'b0, window_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || hit_i)  cnt_q <= '0;
    else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/thread_dispatch_sched.sv
module thread_dispatch_sched #(
  parameter int NUM_CTX = 4,
  parameter int DEPTH   = 4,
  parameter int DATA_W  = 16,
  parameter int WIN_W   = 8,
  localparam int IDX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_CTX-1:0]        push_valid_i,
  input  logic [NUM_CTX*DATA_W-1:0] push_data_i,
  output logic [NUM_CTX-1:0]        full_o,
  input  logic [NUM_CTX-1:0]        ctx_en_i,
  input  logic [NUM_CTX-1:0]        ctx_stall_i,
  input  logic [1:0]                mode_i,
  input  logic                      qos_en_i,
  input  logic [IDX_W-1:0]          qos_ctx_i,
  input  logic [WIN_W-1:0]          qos_window_i,
  output logic                      disp_valid_o,
  output logic [IDX_W-1:0]          disp_ctx_o,
  output logic [DATA_W-1:0]         disp_data_o
);
  logic [NUM_CTX-1:0] ctx_empty, elig, pop;
  logic [DATA_W-1:0]  head [NUM_CTX];
  logic [IDX_W-1:0]   last_q, gnt_idx;
  logic               gnt_valid, qos_due, qos_force, qos_in_range;

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
    tds_ctx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push_valid_i[i]),
      .pop_i   (pop[i]),
      .data_i  (push_data_i[i*DATA_W +: DATA_W]),
      .data_o  (head[i]),
      .empty_o (ctx_empty[i]),
      .full_o  (full_o[i])
    );
    assign elig[i] = ctx_en_i[i] && !ctx_stall_i[i] && !ctx_empty[i];
    assign pop[i]  = gnt_valid && (gnt_idx == IDX_W'(i));
  end

  assign qos_in_range = int'(qos_ctx_i) < NUM_CTX;
  assign qos_force    = qos_due && qos_in_range && elig[qos_ctx_i];

  tds_qos_timer #(.WIN_W(WIN_W)) qos_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (qos_en_i),
    .hit_i    (gnt_valid && (gnt_idx == qos_ctx_i)),
    .window_i (qos_window_i),
    .due_o    (qos_due)
  );

  tds_select #(.NUM_CTX(NUM_CTX), .IDX_W(IDX_W)) sel_i (
    .elig_i      (elig),
    .mode_i      (mode_i),
    .last_i      (last_q),
    .force_i     (qos_force),
    .force_idx_i (qos_ctx_i),
    .gnt_valid_o (gnt_valid),
    .gnt_idx_o   (gnt_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        last_q <= IDX_W'(NUM_CTX - 1);
    else if (gnt_valid) last_q <= gnt_idx;
  end

  assign disp_valid_o = gnt_valid;
  assign disp_ctx_o   = gnt_idx;
  assign disp_data_o  = gnt_valid ? head[gnt_idx] : '0;
endmodule

// File: rtl/thread_dispatch_sched_chk.sv
module thread_dispatch_sched_chk #(
  parameter int NUM_CTX = 4,
  parameter int IDX_W   = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_CTX-1:0] ctx_en_i,
  input logic [NUM_CTX-1:0] ctx_stall_i,
  input logic [NUM_CTX-1:0] empty_i,
  input logic [NUM_CTX-1:0] full_i,
  input logic [1:0]         mode_i,
  input logic               qos_en_i,
  input logic               disp_valid_i,
  input logic [IDX_W-1:0]   disp_ctx_i
);
  logic [NUM_CTX-1:0] ready, below;
  logic [IDX_W-1:0]   prev_ctx_q;
  logic               have_prev_q;

  assign ready = ctx_en_i & ~ctx_stall_i & ~empty_i;
  assign below = (NUM_CTX'(1) << disp_ctx_i) - NUM_CTX'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_ctx_q  <= '0;
      have_prev_q <= 1'b0;
    end else if (disp_valid_i) begin
      prev_ctx_q  <= disp_ctx_i;
      have_prev_q <= 1'b1;
    end
  end

  assert_grant_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_i |-> ready[disp_ctx_i]);

  assert_lowest_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && !qos_en_i && disp_valid_i) |-> ((ready & below) == '0));

  assert_rotates_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && !qos_en_i && disp_valid_i && have_prev_q && $countones(ready) >= 2)
      |-> (disp_ctx_i != prev_ctx_q));

  assert_stays_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && !qos_en_i && disp_valid_i && have_prev_q && ready[prev_ctx_q])
      |-> (disp_ctx_i == prev_ctx_q));

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_full
    assert_full_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full_i[i] && !(disp_valid_i && disp_ctx_i == IDX_W'(i))) |=> full_i[i]);
  end
endmodule

bind thread_dispatch_sched thread_dispatch_sched_chk #(.NUM_CTX(NUM_CTX), .IDX_W(IDX_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctx_en_i     (ctx_en_i),
  .ctx_stall_i  (ctx_stall_i),
  .empty_i      (ctx_empty),
  .full_i       (full_o),
  .mode_i       (mode_i),
  .qos_en_i     (qos_en_i),
  .disp_valid_i (disp_valid_o),
  .disp_ctx_i   (disp_ctx_o)
);

// File: tb/thread_dispatch_sched_tb_top.sv
module thread_dispatch_sched_tb_top;
  localparam int N  = 4;
  localparam int D  = 4;
  localparam int W  = 16;
  localparam int QW = 8;
  localparam int IW = 2;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N-1:0]    push_valid_i = '0;
  logic [N*W-1:0]  push_data_i = '0;
  logic [N-1:0]    full_o;
  logic [N-1:0]    ctx_en_i = '0;
  logic [N-1:0]    ctx_stall_i = '0;
  logic [1:0]      mode_i = '0;
  logic            qos_en_i = 1'b0;
  logic [IW-1:0]   qos_ctx_i = '0;
  logic [QW-1:0]   qos_window_i = '0;
  logic            disp_valid_o;
  logic [IW-1:0]   disp_ctx_o;
  logic [W-1:0]    disp_data_o;

  always #2 clk_i = ~clk_i;

  thread_dispatch_sched #(.NUM_CTX(N), .DEPTH(D), .DATA_W(W), .WIN_W(QW)) dut_i (.*);

  int mbuf [N][D];
  int mhd [N];
  int mcnt [N];
  int mlast, mqcnt, seq;
  int checks, fails;
  bit done;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin mhd[i] = 0; mcnt[i] = 0; end
    mlast = N - 1;
    mqcnt = 0;
  endtask

  // inputs are set just after a negedge; compare, then advance model past the posedge
  task automatic step(string req);
    bit el [N];
    int ev, ec, pick, c;
    #1;
    for (int i = 0; i < N; i++) el[i] = ctx_en_i[i] && !ctx_stall_i[i] && mcnt[i] > 0;
    ev = 0; ec = 0;
    for (int i = 0; i < N; i++) if (el[i]) ev = 1;
    if (ev == 1) begin
      if (qos_en_i && (mqcnt + 1 >= int'(qos_window_i)) && el[qos_ctx_i]) ec = int'(qos_ctx_i);
      else if (mode_i == 2'd1) begin
        pick = -1;
        for (int i = 0; i < N; i++) if (pick < 0 && el[i]) pick = i;
        ec = pick;
      end else if (mode_i == 2'd2 && el[mlast]) ec = mlast;
      else begin
        pick = -1;
        for (int k = 1; k <= N; k++) begin
          c = (mlast + k) % N;
          if (pick < 0 && el[c]) pick = c;
        end
        ec = pick;
      end
    end
    chk(disp_valid_o == ev[0], req, "disp_valid", int'(disp_valid_o), ev);
    if (ev == 1) begin
      chk(int'(disp_ctx_o) == ec, req, "disp_ctx", int'(disp_ctx_o), ec);
      chk(int'(disp_data_o) == mbuf[ec][mhd[ec]], "R4", "disp_data", int'(disp_data_o), mbuf[ec][mhd[ec]]);
    end
    for (int i = 0; i < N; i++)
      chk(full_o[i] == (mcnt[i] == D), "R2", $sformatf("full_o[%0d]", i), int'(full_o[i]), int'(mcnt[i] == D));
    @(posedge clk_i);
    for (int i = 0; i < N; i++) begin
      if (push_valid_i[i] && mcnt[i] < D) begin
        mbuf[i][(mhd[i] + mcnt[i]) % D] = int'(push_data_i[i*W +: W]);
        mcnt[i]++;
      end
    end
    if (ev == 1) begin
      mhd[ec] = (mhd[ec] + 1) % D;
      mcnt[ec]--;
      mlast = ec;
    end
    if (!qos_en_i || (ev == 1 && ec == int'(qos_ctx_i))) mqcnt = 0;
    else if (mqcnt < 255) mqcnt++;
    @(negedge clk_i);
  endtask

  task automatic drive_rand(int push_pct, int stall_pct, int en_pct);
    for (int i = 0; i < N; i++) begin
      push_valid_i[i] = ($urandom_range(99) < push_pct);
      ctx_stall_i[i]  = ($urandom_range(99) < stall_pct);
      ctx_en_i[i]     = ($urandom_range(99) < en_pct);
      seq++;
      push_data_i[i*W +: W] = W'(seq);
    end
  endtask

  task automatic run(string req, int cycles, int mode, int push_pct, int stall_pct, int en_pct,
                     bit qen, int qctx, int win);
    mode_i = 2'(mode);
    qos_en_i = qen;
    qos_ctx_i = IW'(qctx);
    qos_window_i = QW'(win);
    for (int n = 0; n < cycles; n++) begin
      drive_rand(push_pct, stall_pct, en_pct);
      step(req);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; seq = 0; done = 0;
    model_reset();
    repeat (3) @(negedge clk_i);
    // R1: reset state seen at the ports while reset is held
    chk(disp_valid_o == 1'b0, "R1", "disp_valid in reset", int'(disp_valid_o), 0);
    chk(full_o == '0, "R1", "full_o in reset", int'(full_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step("R1");

    // R9: fill every context, first rotating grant goes to context 0
    for (int n = 0; n < 2; n++) begin
      ctx_en_i = '0;
      push_valid_i = '1;
      for (int i = 0; i < N; i++) begin seq++; push_data_i[i*W +: W] = W'(seq); end
      step("R9");
    end
    push_valid_i = '0;
    ctx_en_i = '1;
    mode_i = 2'd0;
    step("R9");
    for (int n = 0; n < 6; n++) step("R5");

    // R2: overflow a disabled context, then drain it in order
    ctx_en_i = '0;
    for (int n = 0; n < 8; n++) begin
      push_valid_i = 4'b0001;
      seq++;
      push_data_i[0 +: W] = W'(seq);
      step("R2");
    end
    push_valid_i = '0;
    ctx_en_i = 4'b0001;
    for (int n = 0; n < 6; n++) step("R2");

    // R3: everything stalled or disabled gives no dispatch
    run("R3", 200, 0, 60, 100, 90, 0, 0, 0);
    run("R3", 200, 0, 60, 40, 50, 0, 0, 0);
    run("R5", 3000, 0, 50, 20, 90, 0, 0, 0);
    run("R5", 500, 3, 50, 20, 90, 0, 0, 0);
    run("R6", 3000, 1, 40, 20, 90, 0, 0, 0);
    run("R7", 3000, 2, 50, 15, 90, 0, 0, 0);
    run("R8", 3000, 1, 70, 10, 95, 1, 3, 5);
    run("R8", 2000, 2, 70, 10, 95, 1, 2, 3);
    run("R8", 1000, 0, 70, 10, 95, 1, 1, 1);
    run("R9", 2000, 0, 50, 20, 90, 1, 0, 7);
    run("R4", 2000, 2, 90, 5, 100, 0, 0, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule